// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block gathers error indications from surrounding logic into a fault register and lets software inspect, filter and clear them over a simple 64-bit word-addressed register bus. Next to the fault register it keeps a mask register, two action registers that tell downstream routing what to do with each error, and a first-error register. The first-error register records which unmasked bits were set when the first error arrived.

The fault and mask registers each answer at three addresses: a direct write, an AND-clear alias and an OR-set alias. The aliases let software clear or set single bits without a read-modify-write sequence. A parameter chooses how many of the high-order bits are implemented. Bits outside that set always read zero. An attention output is high while any unmasked fault bit is set. A write to an undecoded address is dropped and raises a one-cycle flag.

Data on the bus is big-endian. The most significant bus bit (bit 63) is error bit 0. With IMPL_BITS = N, bus bits 63 down to 64-N are implemented.

Top module: `fir_bank`

## Requirements
- R1: After reset, every register reads zero, and `attn` and `unimp_wr` are low.
- R2: A write to word address 0 loads the fault register with the write data ANDed with the implemented-bits mask. With the default IMPL_BITS = 28, that mask is 64'hFFFF_FFF0_0000_0000.
- R3: A write to word address 1 replaces the fault register with its current value ANDed with the write data. A zero in the data clears that bit.
- R4: A write to word address 2 ORs the write data, restricted to the implemented bits, into the fault register.
- R5: The mask register has the same three forms: direct write at address 3, AND-clear at address 4 and OR-set at address 5. All three are restricted to the implemented bits.
- R6: Addresses 6 and 7 hold the two action registers. Each is written directly with the data ANDed with the implemented-bits mask.
- R7: Any write to address 8, the first-error register, sets it to zero whatever the data.
- R8: A read (`rd_en`) returns the stored value on `rdata` with `rvalid` one cycle later. Addresses 9, 10 and 11 are report/status words: writes to them are accepted and have no effect, and they read zero.
- R9: A write to an address above 11 changes no register and pulses `unimp_wr` high for exactly one cycle. A read of such an address returns zero.
- R10: A one-cycle `hw_err` vector ORs its implemented bits into the fault register. This also happens in the same cycle as any software write to the fault register, in which case the hardware bits are applied on top of the software result.
- R11: When `hw_err` carries unmasked implemented bits and the first-error register is zero or is being written that cycle, the register captures those bits. The mask used is the one held before that edge. Otherwise the register holds its value.
- R12: `attn` is high exactly while (fault AND NOT mask) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address of the access |
| wdata | input | DATA_W | Write data, big-endian bit order |
| rdata | output | DATA_W | Read data, one cycle after `rd_en` |
| rvalid | output | 1 | `rdata` is valid |
| hw_err | input | DATA_W | One-cycle hardware error pulses |
| attn | output | 1 | Unmasked fault present |
| unimp_wr | output | 1 | One-cycle flag for a write to an undecoded address |

## Verification
The hardware error pulse and a software write can both land on the fault register or the first-error register in the same clock. The bench provokes this by raising `hw_err` in the same cycle as an AND-clear with all-zero data, and again in the same cycle as a clearing write to the first-error register. It then reads back both registers. The check passes only if the fault register holds exactly the hardware bits and the first-error register holds the freshly captured unmasked bits rather than zero.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // Word addresses decoded by the bank
    localparam int unsigned ADR_FAULT     = 0;
    localparam int unsigned ADR_FAULT_AND = 1;
    localparam int unsigned ADR_FAULT_OR  = 2;
    localparam int unsigned ADR_MASK      = 3;
    localparam int unsigned ADR_MASK_AND  = 4;
    localparam int unsigned ADR_MASK_OR   = 5;
    localparam int unsigned ADR_ACT0      = 6;
    localparam int unsigned ADR_ACT1      = 7;
    localparam int unsigned ADR_FIRST     = 8;
    localparam int unsigned ADR_RPT_LO    = 9;
    localparam int unsigned ADR_RPT_HI    = 11;

    typedef struct packed {
        logic fault_dir;
        logic fault_and;
        logic fault_or;
        logic mask_dir;
        logic mask_and;
        logic mask_or;
        logic act0;
        logic act1;
        logic first;
        logic quiet;   // accepted, no effect
        logic undef;   // undecoded address
    } fir_sel_t;

    // Mask of the IMPL high-order bits of a W-bit word (MSB-first numbering)
    function automatic logic [63:0] impl_mask64(int unsigned w, int unsigned impl);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w && i >= (w - impl)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fir_addr_dec.sv
module fir_addr_dec
    import fir_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output fir_sel_t          sel_o
);
    always_comb begin
        sel_o = '0;
        if (ADDR_W'(ADR_FAULT) == addr_i)          sel_o.fault_dir = 1'b1;
        else if (ADDR_W'(ADR_FAULT_AND) == addr_i) sel_o.fault_and = 1'b1;
        else if (ADDR_W'(ADR_FAULT_OR) == addr_i)  sel_o.fault_or  = 1'b1;
        else if (ADDR_W'(ADR_MASK) == addr_i)      sel_o.mask_dir  = 1'b1;
        else if (ADDR_W'(ADR_MASK_AND) == addr_i)  sel_o.mask_and  = 1'b1;
        else if (ADDR_W'(ADR_MASK_OR) == addr_i)   sel_o.mask_or   = 1'b1;
        else if (ADDR_W'(ADR_ACT0) == addr_i)      sel_o.act0      = 1'b1;
        else if (ADDR_W'(ADR_ACT1) == addr_i)      sel_o.act1      = 1'b1;
        else if (ADDR_W'(ADR_FIRST) == addr_i)     sel_o.first     = 1'b1;
        else if (addr_i >= ADDR_W'(ADR_RPT_LO) && addr_i <= ADDR_W'(ADR_RPT_HI))
                                                   sel_o.quiet     = 1'b1;
        else                                       sel_o.undef     = 1'b1;
    end
endmodule

// File: rtl/fir_alias_reg.sv
module fir_alias_reg #(
    parameter int unsigned           DATA_W = 64,
    parameter logic [DATA_W-1:0]     IMPL   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_dir_i,
    input  logic              wr_and_i,
    input  logic              wr_or_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] set_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] q, sw_nxt;

    always_comb begin
        sw_nxt = q;
        if (wr_dir_i)      sw_nxt = wdata_i;
        else if (wr_and_i) sw_nxt = q & wdata_i;
        else if (wr_or_i)  sw_nxt = q | wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (sw_nxt | set_i) & IMPL;
    end

    assign q_o = q;

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_dir_i && set_i == '0) |=> (q == $past(wdata_i & IMPL)));
    // R3
    and_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_and_i && set_i == '0) |=> ((q & ~$past(wdata_i)) == '0));
    // R4
    or_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_or_i |=> ((q & $past(wdata_i & IMPL)) == $past(wdata_i & IMPL)));
endmodule

// File: rtl/fir_first_cap.sv
module fir_first_cap #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] new_bits_i,  // unmasked implemented hw bits
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] q;
    logic              empty;

    assign empty = (q == '0) || clr_i;

    always_ff @(posedge clk) begin
        if (rst)                              q <= '0;
        else if (empty && new_bits_i != '0)   q <= new_bits_i;
        else if (clr_i)                       q <= '0;
    end

    assign q_o = q;

    // R7
    first_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && new_bits_i == '0) |=> (q == '0));
    // R11
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q != '0 && !clr_i) |=> $stable(q));
endmodule

// File: rtl/fir_bank.sv
module fir_bank
    import fir_pkg::*;
#(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned IMPL_BITS = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic [DATA_W-1:0] hw_err,
    output logic              attn,
    output logic              unimp_wr
);
    localparam logic [63:0]       IMPL64 = impl_mask64(DATA_W, IMPL_BITS);
    localparam logic [DATA_W-1:0] IMPL   = IMPL64[DATA_W-1:0];

    fir_sel_t          sel;
    logic [DATA_W-1:0] fault_q, mask_q, first_q, act_q [2];
    logic [DATA_W-1:0] hw_impl, hw_new, rd_mux;
    logic              unimp_q;

    fir_addr_dec #(.ADDR_W(ADDR_W)) dec_i (.addr_i(addr), .sel_o(sel));

    assign hw_impl = hw_err & IMPL;
    assign hw_new  = hw_impl & ~mask_q;

    fir_alias_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) fault_i (
        .clk(clk), .rst(rst),
        .wr_dir_i(wr_en && sel.fault_dir),
        .wr_and_i(wr_en && sel.fault_and),
        .wr_or_i (wr_en && sel.fault_or),
        .wdata_i(wdata), .set_i(hw_impl), .q_o(fault_q));

    fir_alias_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) mask_i (
        .clk(clk), .rst(rst),
        .wr_dir_i(wr_en && sel.mask_dir),
        .wr_and_i(wr_en && sel.mask_and),
        .wr_or_i (wr_en && sel.mask_or),
        .wdata_i(wdata), .set_i('0), .q_o(mask_q));

    fir_first_cap #(.DATA_W(DATA_W)) first_i (
        .clk(clk), .rst(rst),
        .clr_i(wr_en && sel.first),
        .new_bits_i(hw_new), .q_o(first_q));

    // Action registers: plain direct-write storage
    for (genvar g = 0; g < 2; g++) begin : g_act
        logic hit;
        assign hit = (g == 0) ? sel.act0 : sel.act1;
        always_ff @(posedge clk) begin
            if (rst)               act_q[g] <= '0;
            else if (wr_en && hit) act_q[g] <= wdata & IMPL;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel.fault_dir || sel.fault_and || sel.fault_or) rd_mux = fault_q;
        else if (sel.mask_dir || sel.mask_and || sel.mask_or) rd_mux = mask_q;
        else if (sel.act0)  rd_mux = act_q[0];
        else if (sel.act1)  rd_mux = act_q[1];
        else if (sel.first) rd_mux = first_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            rvalid  <= 1'b0;
            unimp_q <= 1'b0;
        end else begin
            rvalid  <= rd_en;
            unimp_q <= wr_en && sel.undef;
            if (rd_en) rdata <= rd_mux;
        end
    end

    assign attn     = |(fault_q & ~mask_q);
    assign unimp_wr = unimp_q;

    // R9
    unimp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.undef) |=> (unimp_wr && $stable(fault_q) && $stable(mask_q)));
    // R10
    hw_sets_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_impl != '0) |=> ((fault_q & $past(hw_impl)) == $past(hw_impl)));
endmodule

// File: tb/fir_bank_tb.sv
module fir_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst, wr_en, rd_en, rvalid, attn, unimp_wr;
    logic [3:0]  addr;
    logic [63:0] wdata, rdata, hw_err;
    int          n_chk = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_bank dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .hw_err(hw_err), .attn(attn), .unimp_wr(unimp_wr));

    // {write addr, write data, read addr, expected read}
    localparam logic [135:0] VEC [NV] = '{
        {4'd0,  64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 64'hFFFF_FFF0_0000_0000},
        {4'd1,  64'h0F0F_FFFF_FFFF_FFFF, 4'd0, 64'h0F0F_FFF0_0000_0000},
        {4'd2,  64'hA000_0000_0000_00FF, 4'd0, 64'hAF0F_FFF0_0000_0000},
        {4'd3,  64'h1234_5678_9ABC_DEF0, 4'd3, 64'h1234_5670_0000_0000},
        {4'd4,  64'hFF00_FFFF_0000_0000, 4'd3, 64'h1200_5670_0000_0000},
        {4'd5,  64'h0001_0000_0000_0001, 4'd3, 64'h1201_5670_0000_0000},
        {4'd6,  64'hDEAD_BEEF_CAFE_F00D, 4'd6, 64'hDEAD_BEE0_0000_0000},
        {4'd7,  64'h0123_4567_89AB_CDEF, 4'd7, 64'h0123_4560_0000_0000},
        {4'd9,  64'hFFFF_FFFF_FFFF_FFFF, 4'd9, 64'h0},
        {4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 64'hAF0F_FFF0_0000_0000},
        {4'd13, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3, 64'h1201_5670_0000_0000},
        {4'd1,  64'h0,                   4'd0, 64'h0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R2";  1: return "R3";  2: return "R4";
            3, 4, 5: return "R5";  6, 7: return "R6";
            8, 9: return "R8";  10: return "R9";  default: return "R3";
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [63:0] d, logic [63:0] h);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; hw_err = h;
        @(negedge clk);
        wr_en = 1'b0; hw_err = '0;
    endtask

    task automatic pulse_hw(logic [63:0] h);
        @(negedge clk);
        hw_err = h;
        @(negedge clk);
        hw_err = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        if (rvalid !== 1'b1) begin
            n_chk++; n_err++;
            $display("FAIL R8 actual=rvalid %b expected=1", rvalid);
        end
        d = rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] v;
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; hw_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", {62'd0, attn, unimp_wr}, 64'd0);
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            chk("R1", v, 64'd0);
        end

        // Vector table: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][135:132], VEC[i][131:68], 64'd0);
            rd(VEC[i][67:64], v);
            chk(vec_tag(i), v, VEC[i][63:0]);
        end

        // R9 unimplemented write flag and read
        @(negedge clk);
        wr_en = 1'b1; addr = 4'd14; wdata = '1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9", {63'd0, unimp_wr}, 64'd1);
        @(negedge clk);
        chk("R9", {63'd0, unimp_wr}, 64'd0);
        rd(4'd15, v);
        chk("R9", v, 64'd0);

        // R12 attention
        wr(4'd3, 64'h0, 64'h0);
        chk("R12", {63'd0, attn}, 64'd0);
        wr(4'd2, 64'h8000_0000_0000_0000, 64'h0);
        chk("R12", {63'd0, attn}, 64'd1);
        wr(4'd5, 64'h8000_0000_0000_0000, 64'h0);
        chk("R12", {63'd0, attn}, 64'd0);

        // R10 / R11 hardware errors and first-error capture
        wr(4'd0, 64'h0, 64'h0);
        wr(4'd3, 64'h4000_0000_0000_0000, 64'h0);
        wr(4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        pulse_hw(64'hC000_0000_0000_0000);
        rd(4'd0, v); chk("R10", v, 64'hC000_0000_0000_0000);
        rd(4'd8, v); chk("R11", v, 64'h8000_0000_0000_0000);
        pulse_hw(64'h2000_0000_0000_0000);
        rd(4'd0, v); chk("R10", v, 64'hE000_0000_0000_0000);
        rd(4'd8, v); chk("R11", v, 64'h8000_0000_0000_0000);
        // Collision: AND-clear with zeros plus hw pulse
        wr(4'd1, 64'h0, 64'h1000_0000_0000_0000);
        rd(4'd0, v); chk("R10", v, 64'h1000_0000_0000_0000);
        // Collision: first-error clear plus hw pulse
        wr(4'd8, 64'h0, 64'h0800_0000_0000_0000);
        rd(4'd8, v); chk("R11", v, 64'h0800_0000_0000_0000);
        // Plain clear
        wr(4'd8, 64'h1234, 64'h0);
        rd(4'd8, v); chk("R7", v, 64'h0);
        // Unimplemented hw bits ignored
        pulse_hw(64'h0000_0000_0000_000F);
        rd(4'd0, v); chk("R10", v, 64'h1800_0000_0000_0000);
        rd(4'd8, v); chk("R11", v, 64'h0);
        // Masked-only hw bits do not capture
        pulse_hw(64'h4000_0000_0000_0000);
        rd(4'd8, v); chk("R11", v, 64'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule